// File: doc/BRIEF.md
# Page-mode and EDO DRAM controller with CAS-before-RAS refresh

This block sits between a simple processor-side request port and two banks of asynchronous DRAM. The host presents one request at a time: read or write, a 24-bit word address, two byte enables and a flag for a 32-bit transfer. The request is held until the controller answers with a one-cycle `req_ready` pulse. The controller multiplexes row and column addresses onto one address bus. It drives a single RAS strobe shared by both banks, one CAS strobe per bank, one write strobe per byte lane and an output enable.

Rows can stay open between accesses, so a later access to the same row issues only a new column strobe. Read data is captured at the end of the CAS pulse for standard page-mode parts, or one cycle later, after CAS has risen, for EDO parts. All cycle timing is set by configuration inputs in clock cycles, so slower and faster parts can share one design. Refresh runs on its own at one of three rates and always uses CAS-before-RAS cycles. A battery-backup input blocks host access while refresh continues.

Top module: `dram_ctl`

## Requirements
- R1: During and after reset, with no request, `dram_ras_n`=1, `dram_cas_n`=2'b11, `dram_we_n`=2'b11, `dram_oe_n`=1, `dram_dq_oe`=0 and `req_ready`=0.
- R2: An access to a closed row drops RAS with the row address on `dram_addr`. The selected bank's CAS falls exactly max(`cfg_trcd`,1) cycles later, with the column address on `dram_addr`, and stays low for max(`cfg_tcas`,1) cycles.
- R3: With `cfg_page`=1 the row stays open after an access (RAS low at `req_ready`). A later access to the same row produces no RAS falling edge and only one CAS strobe. An access to a different row closes the open row first and then opens the new one.
- R4: With `cfg_page`=0, RAS is high in the cycle `req_ready` is asserted, and every access opens its row again.
- R5: With `cfg_edo`=0, read data is `dram_dq_in` sampled in the last CAS-low cycle. With `cfg_edo`=1 it is sampled in the cycle after CAS rises, during which `dram_oe_n` stays low. A 16-bit read returns the word on `req_rdata[15:0]`.
- R6: `cfg_size` sets the row/column split and the bank bit of the word address. Code 0 (512 KB): row [17:9], column [8:0], bank bit 18. Code 1 (1 MB): row [18:9], column [8:0], bank bit 19. Code 2 (4 MB): row [20:10], column [9:0], bank bit 21. Code 3 (16 MB): row [22:11], column [10:0], bank bit 23. Bank 0 drives `dram_cas_n`=2'b10 and bank 1 drives 2'b01.
- R7: A 32-bit access (`req_wide`=1) uses one row opening and two CAS strobes, at the column with bit 0 cleared and then with bit 0 set. The first word travels on bits [15:0] and the second on bits [31:16] of the data.
- R8: On a write, `dram_we_n[i]` is low during CAS only for byte lanes with `req_be[i]`=1. For 32-bit writes both lanes are written. `dram_dq_oe` is high while a write strobe is low, with the current word on `dram_dq_out`.
- R9: A refresh drops both CAS lines first. RAS follows after max(`cfg_tcsr`,1) cycles and stays low for max(`cfg_tras`,1) cycles. RAS and both CAS lines then rise together, and RAS stays high for max(`cfg_trp`,1) cycles. No write strobe or output enable is active during refresh.
- R10: Refresh starts recur every REF_FAST, REF_NORM or REF_SLOW cycles for `cfg_rate` codes 0, 1 and 2; code 3 behaves as code 2.
- R11: A due refresh comes before a waiting request. An open row is closed, with RAS high for the precharge time, before the refresh CAS falls, and the next access opens its row again.
- R12: While `battery` is high no request is accepted and `req_ready` stays low, but refresh continues. A request held across the battery period is served once `battery` falls.
- R13: `req_ready` is a single-cycle pulse per request, and the request is not taken a second time in the cycle of that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present, held until `req_ready` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Word address, including the bank bit |
| req_be | input | 2 | Byte-lane enables for 16-bit writes |
| req_wide | input | 1 | 32-bit transfer as two column cycles |
| req_wdata | input | 32 | Write data, low word first |
| req_ready | output | 1 | One-cycle completion pulse |
| req_rdata | output | 32 | Read data, valid with `req_ready` |
| cfg_size | input | 2 | Bank size code |
| cfg_rate | input | 2 | Refresh rate code |
| cfg_edo | input | 1 | EDO read capture |
| cfg_page | input | 1 | Keep rows open between accesses |
| cfg_trcd | input | 4 | RAS-to-CAS delay, cycles |
| cfg_tcas | input | 4 | CAS pulse width, cycles |
| cfg_trp | input | 4 | RAS precharge, cycles |
| cfg_tras | input | 4 | Refresh RAS-low time, cycles |
| cfg_tcsr | input | 4 | Refresh CAS-to-RAS setup, cycles |
| battery | input | 1 | Battery backup: lock out host, keep refresh |
| dram_addr | output | 12 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Shared row strobe |
| dram_cas_n | output | 2 | Column strobe per bank |
| dram_we_n | output | 2 | Write strobe per byte lane |
| dram_oe_n | output | 1 | Output enable |
| dram_dq_out | output | 16 | Write data to DRAM |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |
| dram_dq_in | input | 16 | Read data from DRAM |

## Verification
A stuck or wrong open-row record shows up at the first access that follows it. Either a RAS edge appears where only a CAS strobe was due, or a column strobe lands on a row that was never opened and returns the wrong data word. A miscounted timing counter moves the CAS or RAS edge by a cycle within the same access, and the edge-to-edge distances on the strobes show this. A lost refresh request shows up as a missing CAS-before-RAS cycle within one refresh period. A capture point in the wrong place returns the neighbouring data pattern in the same transfer.

// File: rtl/dram_ctl.sv
module dram_ctl #(
  parameter int REF_FAST = 390,
  parameter int REF_NORM = 780,
  parameter int REF_SLOW = 1560,
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [23:0]   req_addr,
  input  logic [1:0]    req_be,
  input  logic          req_wide,
  input  logic [31:0]   req_wdata,
  output logic          req_ready,
  output logic [31:0]   req_rdata,
  input  logic [1:0]    cfg_size,
  input  logic [1:0]    cfg_rate,
  input  logic          cfg_edo,
  input  logic          cfg_page,
  input  logic [TW-1:0] cfg_trcd,
  input  logic [TW-1:0] cfg_tcas,
  input  logic [TW-1:0] cfg_trp,
  input  logic [TW-1:0] cfg_tras,
  input  logic [TW-1:0] cfg_tcsr,
  input  logic          battery,
  output logic [11:0]   dram_addr,
  output logic          dram_ras_n,
  output logic [1:0]    dram_cas_n,
  output logic [1:0]    dram_we_n,
  output logic          dram_oe_n,
  output logic [15:0]   dram_dq_out,
  output logic          dram_dq_oe,
  input  logic [15:0]   dram_dq_in
);
  localparam int RCW = $clog2(REF_SLOW + 1);

  typedef enum logic [2:0] {S_IDLE, S_ROW, S_COL, S_CHI, S_PRE, S_RFC, S_RFR} st_t;

  st_t            st;
  logic [TW-1:0]  cnt;
  logic           row_open, ref_pend, ack_q, wsel;
  logic [11:0]    open_row, l_col, req_row, req_col, ecol;
  logic           l_bank, req_bank, l_wr, l_wide;
  logic [1:0]     l_be;
  logic [31:0]    l_wdata;
  logic [RCW-1:0] ref_cnt, period;

  function automatic logic [TW-1:0] ld(input logic [TW-1:0] t);
    return (t == '0) ? '0 : t - 1'b1;
  endfunction

  always_comb begin
    case (cfg_size)
      2'd0: begin req_row = {3'b0, req_addr[17:9]};  req_col = {3'b0, req_addr[8:0]};  req_bank = req_addr[18]; end
      2'd1: begin req_row = {2'b0, req_addr[18:9]};  req_col = {3'b0, req_addr[8:0]};  req_bank = req_addr[19]; end
      2'd2: begin req_row = {1'b0, req_addr[20:10]}; req_col = {2'b0, req_addr[9:0]};  req_bank = req_addr[21]; end
      default: begin req_row = req_addr[22:11];      req_col = {1'b0, req_addr[10:0]}; req_bank = req_addr[23]; end
    endcase
  end

  always_comb begin
    case (cfg_rate)
      2'd0:    period = RCW'(REF_FAST - 1);
      2'd1:    period = RCW'(REF_NORM - 1);
      default: period = RCW'(REF_SLOW - 1);
    endcase
  end

  wire take = req_valid && !battery && !ack_q;
  wire hit  = row_open && (req_row == open_row);
  wire done = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; row_open <= 1'b0; ref_pend <= 1'b0; ack_q <= 1'b0;
      wsel <= 1'b0; open_row <= '0; l_col <= '0; l_bank <= 1'b0; l_wr <= 1'b0;
      l_wide <= 1'b0; l_be <= '0; l_wdata <= '0; req_rdata <= '0;
      ref_cnt <= RCW'(REF_SLOW - 1);
    end else begin
      ack_q <= 1'b0;
      case (st)
        S_IDLE: begin
          if (ref_pend) begin
            if (row_open) begin
              st <= S_PRE; cnt <= ld(cfg_trp); row_open <= 1'b0;
            end else begin
              st <= S_RFC; cnt <= ld(cfg_tcsr); ref_pend <= 1'b0;
            end
          end else if (take) begin
            if (row_open && !hit) begin
              st <= S_PRE; cnt <= ld(cfg_trp); row_open <= 1'b0;
            end else begin
              l_col <= req_col; l_bank <= req_bank; l_wr <= req_write;
              l_wide <= req_wide; l_be <= req_be; l_wdata <= req_wdata; wsel <= 1'b0;
              if (hit) begin
                st <= S_COL; cnt <= ld(cfg_tcas);
              end else begin
                st <= S_ROW; cnt <= ld(cfg_trcd); open_row <= req_row; row_open <= 1'b1;
              end
            end
          end
        end
        S_ROW: if (done) begin st <= S_COL; cnt <= ld(cfg_tcas); end else cnt <= cnt - 1'b1;
        S_COL: begin
          if (done) begin
            st <= S_CHI;
            if (!cfg_edo && !l_wr) begin
              if (wsel) req_rdata[31:16] <= dram_dq_in; else req_rdata[15:0] <= dram_dq_in;
            end
          end else cnt <= cnt - 1'b1;
        end
        S_CHI: begin
          if (cfg_edo && !l_wr) begin
            if (wsel) req_rdata[31:16] <= dram_dq_in; else req_rdata[15:0] <= dram_dq_in;
          end
          if (l_wide && !wsel) begin
            wsel <= 1'b1; st <= S_COL; cnt <= ld(cfg_tcas);
          end else begin
            ack_q <= 1'b1;
            if (cfg_page) st <= S_IDLE;
            else begin st <= S_PRE; cnt <= ld(cfg_trp); row_open <= 1'b0; end
          end
        end
        S_PRE: begin
          if (done) begin
            if (ref_pend) begin st <= S_RFC; cnt <= ld(cfg_tcsr); ref_pend <= 1'b0; end
            else st <= S_IDLE;
          end else cnt <= cnt - 1'b1;
        end
        S_RFC: if (done) begin st <= S_RFR; cnt <= ld(cfg_tras); end else cnt <= cnt - 1'b1;
        S_RFR: if (done) begin st <= S_PRE; cnt <= ld(cfg_trp); end else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
      if (ref_cnt == '0) begin
        ref_cnt <= period; ref_pend <= 1'b1;
      end else ref_cnt <= ref_cnt - 1'b1;
    end
  end

  wire in_col = (st == S_COL);
  wire in_ref = (st == S_RFC) || (st == S_RFR);

  assign ecol        = l_wide ? {l_col[11:1], wsel} : l_col;
  assign req_ready   = ack_q;
  assign dram_addr   = (in_col || st == S_CHI) ? ecol : open_row;
  assign dram_ras_n  = !(st == S_ROW || in_col || st == S_CHI || st == S_RFR || (st == S_IDLE && row_open));
  assign dram_cas_n  = in_ref ? 2'b00 : in_col ? (l_bank ? 2'b01 : 2'b10) : 2'b11;
  assign dram_we_n   = (in_col && l_wr) ? ~(l_wide ? 2'b11 : l_be) : 2'b11;
  assign dram_dq_oe  = in_col && l_wr && (l_wide || (l_be != 2'b00));
  assign dram_dq_out = wsel ? l_wdata[31:16] : l_wdata[15:0];
  assign dram_oe_n   = !(!l_wr && (in_col || (st == S_CHI && cfg_edo)));
endmodule

// File: rtl/dram_ctl_checker.sv
module dram_ctl_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       ras_n,
  input logic [1:0] cas_n,
  input logic [1:0] we_n,
  input logic       oe_n,
  input logic       dq_oe,
  input logic       ready
);
  wire acc_cas = (cas_n == 2'b01) || (cas_n == 2'b10);

  a_r2_row_before_column: assert property (@(posedge clk) disable iff (!rst_n)
    acc_cas |-> !ras_n);

  a_r9_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && cas_n == 2'b00) |-> $past(cas_n) == 2'b00);

  a_r9_release_together: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && cas_n == 2'b00) |=> ((!ras_n && cas_n == 2'b00) || (ras_n && cas_n == 2'b11)));

  a_r9_refresh_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_n == 2'b00) |-> (we_n == 2'b11 && oe_n));

  a_r8_write_in_column: assert property (@(posedge clk) disable iff (!rst_n)
    (we_n != 2'b11) |-> acc_cas);

  a_r8_drive_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (we_n != 2'b11 && oe_n));

  a_r5_read_not_driven: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (we_n == 2'b11 && !dq_oe));

  a_r13_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);
endmodule

bind dram_ctl dram_ctl_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(dram_ras_n), .cas_n(dram_cas_n),
  .we_n(dram_we_n), .oe_n(dram_oe_n), .dq_oe(dram_dq_oe), .ready(req_ready)
);

// File: tb/dram_ctl_bench.sv
module dram_ctl_bench;
  localparam int PF = 100, PN = 200, PS = 400;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_wide = 0, battery = 0;
  logic [23:0] req_addr = '0;
  logic [1:0] req_be = 2'b11, cfg_size = 0, cfg_rate = 2;
  logic [31:0] req_wdata = '0, req_rdata;
  logic cfg_edo = 0, cfg_page = 0, req_ready;
  logic [3:0] cfg_trcd = 2, cfg_tcas = 2, cfg_trp = 2, cfg_tras = 3, cfg_tcsr = 1;
  logic [11:0] dram_addr, last_col = '0;
  logic dram_ras_n, dram_oe_n, dram_dq_oe;
  logic [1:0] dram_cas_n, dram_we_n;
  logic [15:0] dram_dq_out, dram_dq_in = '0;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  int n_rf, n_cf, t_rf, t_cf, clen;
  logic [11:0] cols [2];
  logic [15:0] dqs [2];
  logic [11:0] row_at_rf;
  logic [1:0] cas_sel, we_seen;
  logic ras_at_rdy, oe_seen;
  logic [31:0] rd;

  dram_ctl #(.REF_FAST(PF), .REF_NORM(PN), .REF_SLOW(PS)) u_dram_ctl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wide(req_wide), .req_wdata(req_wdata),
    .req_ready(req_ready), .req_rdata(req_rdata), .cfg_size(cfg_size), .cfg_rate(cfg_rate),
    .cfg_edo(cfg_edo), .cfg_page(cfg_page), .cfg_trcd(cfg_trcd), .cfg_tcas(cfg_tcas),
    .cfg_trp(cfg_trp), .cfg_tras(cfg_tras), .cfg_tcsr(cfg_tcsr), .battery(battery),
    .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out),
    .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // DRAM data model: column pattern while a bank CAS is low, held pattern otherwise
  always @(negedge clk) begin
    if (dram_cas_n == 2'b01 || dram_cas_n == 2'b10) begin
      dram_dq_in = {4'hC, dram_addr};
      last_col = dram_addr;
    end else dram_dq_in = {4'hE, last_col};
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic do_acc(input logic wr, input logic [23:0] a, input logic [1:0] be,
                        input logic w, input logic [31:0] wd);
    logic pr;
    logic [1:0] pc;
    bit got, acc, pacc;
    n_rf = 0; n_cf = 0; t_rf = 0; t_cf = 0; clen = 0; we_seen = 2'b11; oe_seen = 0;
    cols[0] = '0; cols[1] = '0; dqs[0] = '0; dqs[1] = '0; row_at_rf = '0; cas_sel = 2'b11;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_be = be; req_wide = w; req_wdata = wd;
    pr = dram_ras_n; pc = dram_cas_n; got = 0;
    for (int k = 0; k < 200 && !got; k++) begin
      @(negedge clk);
      if (pr && !dram_ras_n && dram_cas_n == 2'b11) begin
        if (n_rf == 0) begin t_rf = k; row_at_rf = dram_addr; end
        n_rf++;
      end
      acc = (dram_cas_n == 2'b01 || dram_cas_n == 2'b10);
      pacc = (pc == 2'b01 || pc == 2'b10);
      if (acc && !pacc) begin
        if (n_cf == 0) begin t_cf = k; cas_sel = dram_cas_n; end
        if (n_cf < 2) begin cols[n_cf] = dram_addr; dqs[n_cf] = dram_dq_oe ? dram_dq_out : 16'hxxxx; end
        n_cf++;
      end
      if (acc && n_cf == 1) clen++;
      if (acc && dram_we_n != 2'b11) we_seen = dram_we_n;
      if (!dram_oe_n && !acc && pacc) oe_seen = 1;
      if (req_ready) begin
        got = 1; rd = req_rdata; ras_at_rdy = dram_ras_n; req_valid = 0;
      end
      pr = dram_ras_n; pc = dram_cas_n;
    end
    if (!got) chk("R13 ready timeout", 0, 1);
    @(negedge clk);
    chk("R13 ready single cycle", req_ready, 0);
  endtask

  task automatic wait_ref_start(output int t, output logic r1, output logic r2);
    logic [1:0] pc;
    logic h1, h2;
    bit seen;
    pc = dram_cas_n; h1 = dram_ras_n; h2 = dram_ras_n; seen = 0; t = 0; r1 = 0; r2 = 0;
    for (int k = 0; k < 2000 && !seen; k++) begin
      @(negedge clk);
      if (dram_cas_n == 2'b00 && pc != 2'b00) begin seen = 1; t = cyc; r1 = h1; r2 = h2; end
      h2 = h1; h1 = dram_ras_n; pc = dram_cas_n;
    end
    if (!seen) chk("R10 refresh timeout", 0, 1);
  endtask

  task automatic sync_ref();
    int t;
    logic a, b;
    wait_ref_start(t, a, b);
    for (int k = 0; k < 50 && dram_cas_n == 2'b00; k++) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 ras during reset", dram_ras_n, 1);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk("R1 ras", dram_ras_n, 1);
    chk("R1 cas", dram_cas_n, 2'b11);
    chk("R1 we", dram_we_n, 2'b11);
    chk("R1 oe", dram_oe_n, 1);
    chk("R1 dq_oe", dram_dq_oe, 0);
    chk("R1 ready", req_ready, 0);
  endtask

  task automatic t_closed_read();
    cfg_size = 0; cfg_page = 0; cfg_edo = 0;
    sync_ref();
    do_acc(0, {5'b0, 1'b1, 9'h0A5, 9'h13C}, 2'b11, 0, 0);
    chk("R2 one row open", n_rf, 1);
    chk("R2 row address", row_at_rf, 12'h0A5);
    chk("R2 ras to cas", t_cf - t_rf, 2);
    chk("R2 cas width", clen, 2);
    chk("R2 column address", cols[0], 12'h13C);
    chk("R6 bank1 cas", cas_sel, 2'b01);
    chk("R5 standard capture", rd[15:0], 16'hC13C);
    chk("R4 row closed at ready", ras_at_rdy, 1);
    do_acc(0, {5'b0, 1'b1, 9'h0A5, 9'h13D}, 2'b11, 0, 0);
    chk("R4 same row reopened", n_rf, 1);
  endtask

  task automatic t_page();
    cfg_size = 0; cfg_page = 1; cfg_edo = 0;
    sync_ref();
    do_acc(0, {5'b0, 1'b0, 9'h055, 9'h010}, 2'b11, 0, 0);
    chk("R3 first opens row", n_rf, 1);
    chk("R3 row left open", ras_at_rdy, 0);
    do_acc(0, {5'b0, 1'b0, 9'h055, 9'h011}, 2'b11, 0, 0);
    chk("R3 hit no ras edge", n_rf, 0);
    chk("R3 hit one cas", n_cf, 1);
    chk("R3 hit data", rd[15:0], 16'hC011);
    do_acc(0, {5'b0, 1'b1, 9'h056, 9'h012}, 2'b11, 0, 0);
    chk("R3 miss reopens", n_rf, 1);
    chk("R3 miss new row", row_at_rf, 12'h056);
  endtask

  task automatic t_edo();
    cfg_size = 0; cfg_page = 1; cfg_edo = 1;
    sync_ref();
    do_acc(0, {5'b0, 1'b0, 9'h077, 9'h0A0}, 2'b11, 0, 0);
    chk("R5 edo capture after cas", rd[15:0], 16'hE0A0);
    chk("R5 edo oe held", oe_seen, 1);
    do_acc(0, {5'b0, 1'b0, 9'h077, 9'h0A1}, 2'b11, 0, 0);
    chk("R5 edo page hit capture", rd[15:0], 16'hE0A1);
    cfg_edo = 0; cfg_page = 0;
  endtask

  task automatic t_sizes();
    cfg_page = 0; cfg_edo = 0;
    sync_ref();
    cfg_size = 3;
    do_acc(0, {1'b1, 12'h5A3, 11'h2F1}, 2'b11, 0, 0);
    chk("R6 16MB row", row_at_rf, 12'h5A3);
    chk("R6 16MB col", cols[0], 12'h2F1);
    chk("R6 16MB bank", cas_sel, 2'b01);
    cfg_size = 2;
    do_acc(0, {2'b11, 1'b0, 11'h3C1, 10'h155}, 2'b11, 0, 0);
    chk("R6 4MB row", row_at_rf, 12'h3C1);
    chk("R6 4MB col", cols[0], 12'h155);
    chk("R6 4MB bank", cas_sel, 2'b10);
    cfg_size = 1;
    do_acc(0, {4'b0, 1'b1, 10'h2AB, 9'h0F0}, 2'b11, 0, 0);
    chk("R6 1MB row", row_at_rf, 12'h2AB);
    chk("R6 1MB col", cols[0], 12'h0F0);
    chk("R6 1MB bank", cas_sel, 2'b01);
    cfg_size = 0;
  endtask

  task automatic t_wide_and_bytes();
    cfg_size = 0; cfg_page = 0; cfg_edo = 0;
    sync_ref();
    do_acc(0, {5'b0, 1'b0, 9'h033, 9'h040}, 2'b11, 1, 0);
    chk("R7 one row", n_rf, 1);
    chk("R7 two columns", n_cf, 2);
    chk("R7 first col", cols[0], 12'h040);
    chk("R7 second col", cols[1], 12'h041);
    chk("R7 read data", rd, 32'hC041C040);
    do_acc(1, {5'b0, 1'b1, 9'h011, 9'h024}, 2'b00, 1, 32'hBEEF1234);
    chk("R7 write low word", dqs[0], 16'h1234);
    chk("R7 write high word", dqs[1], 16'hBEEF);
    chk("R8 wide both lanes", we_seen, 2'b00);
    do_acc(1, {5'b0, 1'b1, 9'h011, 9'h022}, 2'b10, 0, 32'h0000A55A);
    chk("R8 upper lane only", we_seen, 2'b01);
    chk("R8 write data", dqs[0], 16'hA55A);
    do_acc(1, {5'b0, 1'b1, 9'h011, 9'h023}, 2'b01, 0, 32'h00003C3C);
    chk("R8 lower lane only", we_seen, 2'b10);
  endtask

  task automatic t_refresh();
    int t, a, b;
    logic r1, r2;
    bit out;
    wait_ref_start(t, r1, r2);
    a = 0; b = 0; out = 0;
    for (int k = 0; k < 40 && !out; k++) begin
      if (dram_cas_n == 2'b00 && dram_ras_n) a++;
      else if (dram_cas_n == 2'b00) b++;
      else begin
        out = 1;
        chk("R9 cas released with ras", dram_cas_n, 2'b11);
        chk("R9 ras released", dram_ras_n, 1);
      end
      if (!out) @(negedge clk);
    end
    chk("R9 cas-to-ras setup", a, 1);
    chk("R9 ras active", b, 3);
    @(negedge clk);
    chk("R9 precharge", dram_ras_n, 1);
  endtask

  task automatic t_ref_close();
    int t;
    logic r1, r2;
    cfg_size = 0; cfg_page = 1;
    sync_ref();
    do_acc(0, {5'b0, 1'b0, 9'h0C3, 9'h005}, 2'b11, 0, 0);
    chk("R11 page open before refresh", dram_ras_n, 0);
    wait_ref_start(t, r1, r2);
    chk("R11 closed before refresh", {r2, r1}, 2'b11);
    repeat (8) @(negedge clk);
    do_acc(0, {5'b0, 1'b0, 9'h0C3, 9'h006}, 2'b11, 0, 0);
    chk("R11 row reopened after refresh", n_rf, 1);
    cfg_page = 0;
  endtask

  task automatic t_rates();
    int t0, t1, t2;
    logic a, b;
    for (int r = 0; r < 4; r++) begin
      cfg_rate = 2'(r);
      wait_ref_start(t0, a, b);
      wait_ref_start(t1, a, b);
      wait_ref_start(t2, a, b);
      chk("R10 refresh interval", t2 - t1, (r == 0) ? PF : (r == 1) ? PN : PS);
    end
  endtask

  task automatic t_battery();
    int nref, nrdy, nacc;
    logic [1:0] pc;
    bit got;
    cfg_rate = 0; cfg_page = 0; cfg_edo = 0; cfg_size = 0;
    sync_ref();
    sync_ref();
    @(negedge clk);
    battery = 1;
    req_valid = 1; req_write = 0; req_addr = {5'b0, 1'b0, 9'h0AA, 9'h0BB}; req_wide = 0; req_be = 2'b11;
    nref = 0; nrdy = 0; nacc = 0; pc = dram_cas_n;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (dram_cas_n == 2'b00 && pc != 2'b00) nref++;
      if (dram_cas_n == 2'b01 || dram_cas_n == 2'b10) nacc++;
      if (req_ready) nrdy++;
      pc = dram_cas_n;
    end
    chk("R12 no ready in backup", nrdy, 0);
    chk("R12 no access in backup", nacc, 0);
    chk("R12 refresh runs in backup", nref >= 2, 1);
    battery = 0;
    got = 0;
    for (int k = 0; k < 60 && !got; k++) begin
      @(negedge clk);
      if (req_ready) begin got = 1; rd = req_rdata; req_valid = 0; end
    end
    chk("R12 served after backup", got, 1);
    chk("R12 data after backup", rd[15:0], 16'hC0BB);
    cfg_rate = 2;
  endtask

  initial begin
    t_reset();
    t_closed_read();
    t_page();
    t_edo();
    t_sizes();
    t_wide_and_bytes();
    t_refresh();
    t_ref_close();
    t_rates();
    t_battery();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule